// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is a slave on a two-wire serial bus (I2C-compatible) that fronts a byte-wide memory of 2^ADDR_W locations held on chip. Both bus lines are brought in raw. Each one passes through a synchronizer and a stability filter running on a fast system clock. The block answers with a single open-drain pull-down request for the data line. It recognises start and stop conditions, decodes a device address byte and a word address byte, and carries out byte writes, page writes of up to PAGE_BYTES bytes, current-address reads and sequential reads.

Received write data is held in a page buffer. It reaches the memory only when a stop condition closes the write. The buffered bytes are then copied one per clock during a busy window of BUSY_CYCLES system clocks. While that window runs, the device address is not acknowledged, so a master can poll until the slave answers again. A write-protect input, when high at the stop, cancels the store.

Top module: `twowire_eeprom_slave`

## Requirements
- R1: A start condition is a falling data line while the clock line is high, and a stop is a rising data line while the clock line is high. Without a preceding start, clocked bytes get no acknowledge. A stop ends any command.
- R2: The device byte is sent MSB first. Bits [7:4] must equal 4'b1010, and bit 0 selects read (1) or write (0). The ADDR_W-8 lowest bits of [3:1], counted from bit 1, give the upper address bits, and any further bits of that field are ignored. A matching byte is acknowledged by pulling the data line low for the ninth clock. A non-matching byte gets no acknowledge, and the slave then ignores the bus until the next start.
- R3: In a write, the byte after the device byte sets address bits [7:0]. The address byte and every data byte after it are acknowledged.
- R4: Write data is stored only when a stop ends the write. A repeated start drops the pending bytes, stores nothing, and starts no busy window.
- R5: Within a write, successive bytes go to successive addresses. Only the low log2(PAGE_BYTES) address bits count up, wrapping inside the page. Bytes beyond PAGE_BYTES overwrite the earliest ones of the same write.
- R6: A stop that stores at least one byte starts a busy window of BUSY_CYCLES clocks. During that window the device byte is not acknowledged. After it, the device byte is acknowledged again.
- R7: If the write-protect input is high at the stop, the data bytes are still acknowledged, but nothing is stored and no busy window starts.
- R8: A read sends the byte at the current address MSB first, each bit changing after a falling clock edge. The address then increments and wraps from the last location to 0. A read with no address phase continues from the address after the last byte read.
- R9: When the master does not acknowledge a read byte, the slave releases the data line and keeps it released until the next start.
- R10: A pulse on either line shorter than FILT_LEN system clocks is rejected and changes nothing.
- R11: After reset, the data line is released, the slave is idle and it is not busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_in | input | 1 | Raw bus clock line |
| sda_in | input | 1 | Raw bus data line, as seen on the wire |
| wp_in | input | 1 | Write protect; high blocks stores |
| sda_drive_low | output | 1 | High requests the data line be pulled low |

## Verification
The bench builds the block with ADDR_W=9, PAGE_BYTES=16, SYNC_STAGES=2, FILT_LEN=3 and BUSY_CYCLES=1500. A 512-byte array lets a sequential read cross from the top address to 0 in a few bytes, so the wrap is reached quickly. A 1500-clock busy window is long enough that a poll issued right after a stop lands inside it, and short enough that waiting it out stays cheap. With a 3-sample filter and a 12-clock bus quarter period, a 2-clock glitch on the clock line falls below the filter threshold. A bench model of the memory, updated by the page rules, predicts every byte read back.

// File: rtl/ee_pkg.sv
package ee_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_DEV,
    PH_WADR,
    PH_WDAT,
    PH_RDAT,
    PH_HALT
  } phase_t;

  localparam logic [3:0] DEV_FAMILY = 4'b1010;

  // device byte family match
  function automatic logic dev_hit(input logic [7:0] b);
    return b[7:4] == DEV_FAMILY;
  endfunction

  // increment across the whole array, wrapping at 2^w
  function automatic logic [15:0] addr_wrap_inc(input logic [15:0] a, input int unsigned w);
    logic [15:0] m;
    m = 16'((32'd1 << w) - 32'd1);
    return (a + 16'd1) & m;
  endfunction

  // increment only the low pw bits, page stays fixed
  function automatic logic [15:0] page_roll_inc(input logic [15:0] a, input int unsigned pw);
    logic [15:0] m;
    m = 16'((32'd1 << pw) - 32'd1);
    return (a & ~m) | ((a + 16'd1) & m);
  endfunction

  // bit of the transmit byte sent after the c-th rising clock
  function automatic logic [2:0] tx_bit_idx(input logic [3:0] c);
    return 3'(4'd7 - c);
  endfunction

endpackage

// File: rtl/ee_line_filter.sv
module ee_line_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic clean_o
);
  localparam int CNT_W = $clog2(FILT_LEN + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CNT_W-1:0]       run_q;
  logic                   synced;

  assign synced = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= SYNC_STAGES'({sync_q, raw_i});
  end

  // output follows only after FILT_LEN consecutive differing samples
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clean_o <= 1'b1;
      run_q   <= '0;
    end else if (synced == clean_o) begin
      run_q <= '0;
    end else if (run_q == CNT_W'(FILT_LEN - 1)) begin
      clean_o <= synced;
      run_q   <= '0;
    end else begin
      run_q <= run_q + 1'b1;
    end
  end

  // R10
  glitch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clean_o != $past(clean_o)) |-> (clean_o == $past(synced)));

endmodule

// File: rtl/ee_bus_events.sv
module ee_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign start_o = scl_i && scl_q && sda_q && !sda_i;
  assign stop_o  = scl_i && scl_q && !sda_q && sda_i;
  assign rise_o  = scl_i && !scl_q;
  assign fall_o  = !scl_i && scl_q;

  // R1
  cond_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_o && stop_o) && !((start_o || stop_o) && (rise_o || fall_o)));

endmodule

// File: rtl/ee_page_store.sv
module ee_page_store #(
  parameter int ADDR_W      = 11,
  parameter int PAGE_BYTES  = 16,
  parameter int BUSY_CYCLES = 500000
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   clear_i,
  input  logic                                   wr_i,
  input  logic [$clog2(PAGE_BYTES)-1:0]          slot_i,
  input  logic [7:0]                             data_i,
  input  logic                                   commit_i,
  input  logic [ADDR_W-$clog2(PAGE_BYTES)-1:0]   page_i,
  input  logic [ADDR_W-1:0]                      rd_addr_i,
  output logic [7:0]                             rd_data_o,
  output logic                                   busy_o,
  output logic                                   mem_we_o
);
  localparam int PAGE_W = $clog2(PAGE_BYTES);
  localparam int PG_W   = ADDR_W - PAGE_W;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int BCNT_W = $clog2(BUSY_CYCLES + 1);

  logic [7:0]            buf_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] vld_q;
  logic [PG_W-1:0]       page_q;
  logic [BCNT_W-1:0]     bcnt_q;
  logic                  busy_q;
  logic [7:0]            mem [DEPTH];
  logic [PAGE_W-1:0]     sweep_slot;
  logic                  in_sweep;

  assign sweep_slot = bcnt_q[PAGE_W-1:0];
  assign in_sweep   = busy_q && (bcnt_q < BCNT_W'(PAGE_BYTES));
  assign mem_we_o   = in_sweep && vld_q[sweep_slot];
  assign busy_o     = busy_q;
  assign rd_data_o  = mem[rd_addr_i];

  always_ff @(posedge clk) begin
    if (wr_i && !busy_q) buf_q[slot_i] <= data_i;
  end

  always_ff @(posedge clk) begin
    if (mem_we_o) mem[{page_q, sweep_slot}] <= buf_q[sweep_slot];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q  <= '0;
      page_q <= '0;
      bcnt_q <= '0;
      busy_q <= 1'b0;
    end else if (commit_i && !busy_q) begin
      busy_q <= 1'b1;
      bcnt_q <= '0;
      page_q <= page_i;
    end else if (busy_q) begin
      if (mem_we_o) vld_q[sweep_slot] <= 1'b0;
      if (bcnt_q == BCNT_W'(BUSY_CYCLES - 1)) busy_q <= 1'b0;
      else                                    bcnt_q <= bcnt_q + 1'b1;
    end else begin
      if (clear_i) vld_q <= '0;
      if (wr_i)    vld_q[slot_i] <= 1'b1;
    end
  end

  // R4
  commit_from_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(commit_i));

  // R6
  busy_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> ($past(bcnt_q) == BCNT_W'(BUSY_CYCLES - 1)));

endmodule

// File: rtl/ee_slave_ctrl.sv
module ee_slave_ctrl
  import ee_pkg::*;
#(
  parameter int ADDR_W     = 11,
  parameter int PAGE_BYTES = 16
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 start_i,
  input  logic                                 stop_i,
  input  logic                                 rise_i,
  input  logic                                 fall_i,
  input  logic                                 sda_i,
  input  logic                                 scl_i,
  input  logic                                 wp_i,
  input  logic                                 busy_i,
  input  logic [7:0]                           rd_data_i,
  output logic                                 sda_pull_o,
  output logic                                 buf_wr_o,
  output logic [$clog2(PAGE_BYTES)-1:0]        buf_slot_o,
  output logic [7:0]                           buf_data_o,
  output logic                                 buf_clear_o,
  output logic                                 commit_o,
  output logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] page_o,
  output logic [ADDR_W-1:0]                    rd_addr_o,
  output logic                                 in_dev_o
);
  localparam int PAGE_W = $clog2(PAGE_BYTES);

  phase_t            phase;
  logic [3:0]        cnt;
  logic [7:0]        shreg;
  logic [7:0]        tx;
  logic [ADDR_W-1:0] ptr;
  logic              acked;
  logic              have_data;
  logic              mack;
  logic              accept;
  logic [ADDR_W-1:0] ptr_rd_next;
  logic [ADDR_W-1:0] ptr_wr_next;

  always_comb begin
    accept      = (phase == PH_DEV) ? (dev_hit(shreg) && !busy_i) : 1'b1;
    buf_wr_o    = !start_i && !stop_i && fall_i && (phase == PH_WDAT) && (cnt == 4'd8);
    buf_slot_o  = ptr[PAGE_W-1:0];
    buf_data_o  = shreg;
    buf_clear_o = start_i;
    commit_o    = stop_i && (phase == PH_WDAT) && have_data && !wp_i;
    page_o      = ptr[ADDR_W-1:PAGE_W];
    rd_addr_o   = ptr;
    in_dev_o    = (phase == PH_DEV);
    ptr_rd_next = ADDR_W'(addr_wrap_inc(16'(ptr), ADDR_W));
    ptr_wr_next = ADDR_W'(page_roll_inc(16'(ptr), PAGE_W));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase      <= PH_IDLE;
      cnt        <= '0;
      shreg      <= '0;
      tx         <= '0;
      ptr        <= '0;
      acked      <= 1'b0;
      have_data  <= 1'b0;
      mack       <= 1'b0;
      sda_pull_o <= 1'b0;
    end else if (start_i) begin
      phase      <= PH_DEV;
      cnt        <= '0;
      have_data  <= 1'b0;
      sda_pull_o <= 1'b0;
    end else if (stop_i) begin
      phase      <= PH_IDLE;
      cnt        <= '0;
      have_data  <= 1'b0;
      sda_pull_o <= 1'b0;
    end else begin
      case (phase)
        PH_DEV, PH_WADR, PH_WDAT: begin
          if (rise_i) begin
            if (cnt < 4'd8) begin
              shreg <= {shreg[6:0], sda_i};
              cnt   <= cnt + 4'd1;
            end else if (cnt == 4'd8) begin
              cnt <= 4'd9;
            end
          end else if (fall_i) begin
            if (cnt == 4'd8) begin
              sda_pull_o <= accept;
              acked      <= accept;
              if (phase == PH_DEV && accept) ptr[ADDR_W-1:8] <= shreg[ADDR_W-8:1];
              if (phase == PH_WADR) ptr[7:0] <= shreg;
              if (phase == PH_WDAT) begin
                ptr       <= ptr_wr_next;
                have_data <= 1'b1;
              end
            end else if (cnt == 4'd9) begin
              sda_pull_o <= 1'b0;
              cnt        <= '0;
              if (phase == PH_DEV) begin
                if (!acked) begin
                  phase <= PH_IDLE;
                end else if (shreg[0]) begin
                  phase      <= PH_RDAT;
                  tx         <= rd_data_i;
                  sda_pull_o <= ~rd_data_i[7];
                  ptr        <= ptr_rd_next;
                end else begin
                  phase <= PH_WADR;
                end
              end else begin
                phase <= PH_WDAT;
              end
            end
          end
        end
        PH_RDAT: begin
          if (rise_i) begin
            if (cnt < 4'd8) begin
              cnt <= cnt + 4'd1;
            end else if (cnt == 4'd8) begin
              mack <= !sda_i;
              cnt  <= 4'd9;
            end
          end else if (fall_i) begin
            if (cnt >= 4'd1 && cnt <= 4'd7) begin
              sda_pull_o <= ~tx[tx_bit_idx(cnt)];
            end else if (cnt == 4'd8) begin
              sda_pull_o <= 1'b0;
            end else if (cnt == 4'd9) begin
              cnt <= '0;
              if (mack) begin
                tx         <= rd_data_i;
                sda_pull_o <= ~rd_data_i[7];
                ptr        <= ptr_rd_next;
              end else begin
                phase      <= PH_HALT;
                sda_pull_o <= 1'b0;
              end
            end
          end
        end
        default: ;
      endcase
    end
  end

  // R8
  pull_moves_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull_o) |-> !scl_i);

  // R9
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_HALT) |-> !sda_pull_o);

endmodule

// File: rtl/twowire_eeprom_slave.sv
module twowire_eeprom_slave #(
  parameter int ADDR_W      = 11,
  parameter int PAGE_BYTES  = 16,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4,
  parameter int BUSY_CYCLES = 500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  input  logic wp_in,
  output logic sda_drive_low
);
  localparam int PAGE_W = $clog2(PAGE_BYTES);
  localparam int PG_W   = ADDR_W - PAGE_W;

  logic              scl_f, sda_f;
  logic              start_evt, stop_evt, rise_evt, fall_evt;
  logic              busy, mem_we, in_dev;
  logic              buf_wr, buf_clear, commit;
  logic [PAGE_W-1:0] buf_slot;
  logic [7:0]        buf_data, rd_data;
  logic [PG_W-1:0]   page;
  logic [ADDR_W-1:0] rd_addr;

  ee_line_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_scl_filt (
    .clk(clk), .rst_n(rst_n), .raw_i(scl_in), .clean_o(scl_f));

  ee_line_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_sda_filt (
    .clk(clk), .rst_n(rst_n), .raw_i(sda_in), .clean_o(sda_f));

  ee_bus_events u_events (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_f), .sda_i(sda_f),
    .start_o(start_evt), .stop_o(stop_evt), .rise_o(rise_evt), .fall_o(fall_evt));

  ee_slave_ctrl #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .start_i(start_evt), .stop_i(stop_evt), .rise_i(rise_evt), .fall_i(fall_evt),
    .sda_i(sda_f), .scl_i(scl_f), .wp_i(wp_in), .busy_i(busy), .rd_data_i(rd_data),
    .sda_pull_o(sda_drive_low), .buf_wr_o(buf_wr), .buf_slot_o(buf_slot),
    .buf_data_o(buf_data), .buf_clear_o(buf_clear), .commit_o(commit),
    .page_o(page), .rd_addr_o(rd_addr), .in_dev_o(in_dev));

  ee_page_store #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .BUSY_CYCLES(BUSY_CYCLES)) u_store (
    .clk(clk), .rst_n(rst_n), .clear_i(buf_clear), .wr_i(buf_wr), .slot_i(buf_slot),
    .data_i(buf_data), .commit_i(commit), .page_i(page), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .busy_o(busy), .mem_we_o(mem_we));

  // R6
  busy_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && in_dev) |-> !sda_drive_low);

  // R7
  wp_no_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_evt && wp_in && !busy) |=> !busy);

  // R1
  dev_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_dev) |-> $past(start_evt));

  // R4
  store_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (busy && !in_dev));

endmodule

// File: tb/twowire_eeprom_slave_tb.sv
module twowire_eeprom_slave_tb;
  localparam int AW    = 9;
  localparam int PB    = 16;
  localparam int FL    = 3;
  localparam int BUSY  = 1500;
  localparam int Q     = 12;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic wp = 1'b0;
  logic sda_drive_low;
  logic sda_line;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [7:0] shadow [DEPTH];
  logic [7:0] wdat [32];
  logic [7:0] rdat [32];

  assign sda_line = sda_m & ~sda_drive_low;

  always #2 clk = ~clk;

  twowire_eeprom_slave #(
    .ADDR_W(AW), .PAGE_BYTES(PB), .SYNC_STAGES(2), .FILT_LEN(FL), .BUSY_CYCLES(BUSY)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
    .wp_in(wp), .sda_drive_low(sda_drive_low));

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] dev_byte(input logic a8, input logic rw);
    return {4'b1010, rw ? 2'b01 : 2'b10, a8, rw};
  endfunction

  task automatic bus_start();
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input int glitch_bit, output logic ack);
    for (int i = 0; i < 8; i++) begin
      sda_m = b[7-i];
      if (i == glitch_bit) begin
        tick(Q/2); scl_m = 1'b1; tick(FL-1); scl_m = 1'b0; tick(Q/2 - (FL-1));
      end else begin
        tick(Q);
      end
      scl_m = 1'b1; tick(2*Q);
      scl_m = 1'b0; tick(Q);
    end
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    ack = !sda_line;
    tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] d);
    for (int i = 0; i < 8; i++) begin
      sda_m = 1'b1; tick(Q);
      scl_m = 1'b1; tick(Q);
      d[7-i] = sda_line;
      tick(Q);
      scl_m = 1'b0; tick(Q);
    end
    sda_m = !give_ack; tick(Q);
    scl_m = 1'b1; tick(2*Q);
    scl_m = 1'b0; tick(2);
    sda_m = 1'b1; tick(Q-2);
  endtask

  task automatic poll(output logic ack);
    bus_start();
    send_byte(dev_byte(1'b0, 1'b0), -1, ack);
    bus_stop();
  endtask

  task automatic do_write(input logic [8:0] a, input int n, input string tag, input int glitch);
    logic ack;
    bus_start();
    send_byte(dev_byte(a[8], 1'b0), -1, ack);
    chk(ack, "R2 device byte ack", ack, 1);
    send_byte(a[7:0], -1, ack);
    chk(ack, "R3 word address ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      send_byte(wdat[k], (k == 0) ? glitch : -1, ack);
      chk(ack, tag, ack, 1);
    end
    bus_stop();
    if (!wp) begin
      for (int k = 0; k < n; k++) shadow[{a[8:4], 4'(a[3:0] + 4'(k))}] = wdat[k];
    end
  endtask

  task automatic do_read(input logic [8:0] a, input int n, input string tag);
    logic ack;
    bus_start();
    send_byte(dev_byte(a[8], 1'b0), -1, ack);
    send_byte(a[7:0], -1, ack);
    bus_start();
    send_byte(dev_byte(a[8], 1'b1), -1, ack);
    chk(ack, "R2 read device ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      recv_byte(k != n-1, rdat[k]);
      chk(rdat[k] === shadow[9'(a + 9'(k))], tag, rdat[k], shadow[9'(a + 9'(k))]);
    end
    bus_stop();
  endtask

  initial begin
    logic ack;
    logic [7:0] d;
    tick(10);
    chk(sda_drive_low == 1'b0, "R11 released in reset", sda_drive_low, 0);
    rst_n = 1'b1;
    tick(20);
    chk(sda_drive_low == 1'b0, "R11 released after reset", sda_drive_low, 0);
    poll(ack);
    chk(ack, "R11 not busy after reset", ack, 1);

    // R1: byte clocked without a start is ignored
    send_byte(8'hA0, -1, ack);
    chk(!ack, "R1 no start no ack", ack, 0);
    bus_stop();

    // R2: wrong family, then bus ignored
    bus_start();
    send_byte(8'hB0, -1, ack);
    chk(!ack, "R2 mismatch nack", ack, 0);
    send_byte(8'h10, -1, ack);
    chk(!ack, "R2 ignored after mismatch", ack, 0);
    bus_stop();

    // byte write, poll during busy and after
    wdat[0] = 8'h5A;
    do_write(9'h123, 1, "R3 data ack", -1);
    poll(ack);
    chk(!ack, "R6 nack while busy", ack, 0);
    tick(BUSY + 300);
    poll(ack);
    chk(ack, "R6 ack after busy", ack, 1);
    do_read(9'h123, 1, "R3 byte write readback");

    // fill pages 0x000 and 0x080
    for (int k = 0; k < 16; k++) wdat[k] = 8'h30 + 8'(k);
    do_write(9'h000, 16, "R3 data ack", -1);
    tick(BUSY + 300);
    for (int k = 0; k < 16; k++) wdat[k] = 8'h90 + 8'(k);
    do_write(9'h080, 16, "R3 data ack", -1);
    tick(BUSY + 300);

    // R5: page write starting mid-page wraps inside the page
    for (int k = 0; k < 16; k++) wdat[k] = 8'hC0 + 8'(k);
    do_write(9'h1F5, 16, "R5 data ack", -1);
    tick(BUSY + 300);
    do_read(9'h1F0, 16, "R5 page wrap");

    // R5: 18 bytes roll over onto the first two
    for (int k = 0; k < 18; k++) wdat[k] = 8'h60 + 8'(k);
    do_write(9'h040, 18, "R5 data ack", -1);
    tick(BUSY + 300);
    do_read(9'h040, 16, "R5 roll over");

    // R4: repeated start discards pending data
    bus_start();
    send_byte(dev_byte(1'b0, 1'b0), -1, ack);
    send_byte(8'h82, -1, ack);
    for (int k = 0; k < 3; k++) send_byte(8'hEE, -1, ack);
    do_read(9'h080, 4, "R4 discarded on restart");
    poll(ack);
    chk(ack, "R4 no busy after discard", ack, 1);

    // R7: write protect
    wp = 1'b1;
    wdat[0] = 8'h11; wdat[1] = 8'h22;
    do_write(9'h085, 2, "R7 data ack under protect", -1);
    poll(ack);
    chk(ack, "R7 no busy under protect", ack, 1);
    wp = 1'b0;
    do_read(9'h084, 3, "R7 unchanged under protect");

    // R8: sequential read wraps to 0, then current-address read
    do_read(9'h1FE, 4, "R8 wrap to zero");
    bus_start();
    send_byte(dev_byte(1'b0, 1'b1), -1, ack);
    recv_byte(1'b0, d);
    bus_stop();
    chk(d === shadow[2], "R8 current address read", d, shadow[2]);

    // R9: master nack releases the line
    bus_start();
    send_byte(dev_byte(1'b0, 1'b1), -1, ack);
    recv_byte(1'b0, d);
    chk(d === shadow[3], "R9 byte before nack", d, shadow[3]);
    recv_byte(1'b1, d);
    chk(d == 8'hFF, "R9 released after nack", d, 8'hFF);
    bus_stop();

    // R10: short clock glitch during a data bit
    wdat[0] = 8'hA5;
    do_write(9'h0F7, 1, "R10 data ack", 3);
    tick(BUSY + 300);
    do_read(9'h0F7, 1, "R10 glitch rejected");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog act=0 exp=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule